// File: doc/BRIEF.md
# Programmable Loss-of-Signal Detector

This block watches a received byte stream ahead of any descrambler and flags loss of signal. The cause can be either a sustained run of identical uniform bytes, meaning every byte is 0x00 or every byte is 0xFF, or an external loss-of-signal pin. The run length that counts as a loss is set by a threshold input in byte-time units. A threshold of zero is handled as one byte.

Once raised, the loss state is held until a frame aligner reports a set number of consecutive good frames. The default number is two. During that time the external pin must stay low and no qualifying run may be present. Recovery follows the same rule whichever cause raised the state.

The block also reports each change of state as a one-cycle delta event. A copy of that event, gated by an interrupt mask, drives an interrupt line.

Top module: `los_monitor`

## Requirements
- R1: While reset is asserted, and for two clock cycles after its release, `los_state`, `los_delta` and `los_irq` are 0.
- R2: `ext_los` high at a clock edge sets `los_state` to 1 at that edge. The state stays 1 for as long as the pin is high.
- R3: Let N equal `run_thresh`. After N consecutive accepted bytes that are all 0x00, or all 0xFF, `los_state` becomes 1 at the clock edge after the one that accepted the Nth byte. A run of N-1 such bytes followed by a different byte leaves `los_state` at 0. This also holds for the largest threshold, 2047.
- R4: These bytes restart the run count:
  - An accepted byte other than 0x00 or 0xFF restarts the count at zero.
  - A uniform byte of the opposite polarity to the current run (0xFF after 0x00, or the reverse) restarts the count at one.
- R5: Clock cycles with `byte_vld` low neither extend nor break a run.
- R6: A `run_thresh` of 0 behaves exactly like a threshold of 1.
- R7: While `los_state` is 1, with no cause active, `los_state` returns to 0 at the edge that samples the second `frame_ok` pulse.
- R8: A `frame_bad` pulse during recovery discards the good frames counted so far.
- R9: `ext_los` high, or a qualifying run, during recovery discards the good frames counted so far. A `frame_ok` pulse sampled in the same cycle as such a cause is not counted.
- R10: Recovery needs the same frame sequence whether the state was raised by `ext_los` or by a run.
- R11: `los_delta` is high for exactly the one cycle after each edge at which `los_state` changes, in either direction.
- R12: `los_irq` equals `los_delta` when `irq_mask` was 0 at the edge of the change. It is 0 when `irq_mask` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Marks `rx_byte` as one received byte time |
| rx_byte | input | 8 | Received byte, before descrambling |
| run_thresh | input | 11 | Run length in bytes that declares a loss (0 is treated as 1) |
| ext_los | input | 1 | External loss-of-signal indication |
| frame_ok | input | 1 | One-cycle pulse for each frame with a correct, correctly spaced pattern |
| frame_bad | input | 1 | One-cycle pulse for each frame with an errored pattern |
| irq_mask | input | 1 | 1 suppresses the interrupt |
| los_state | output | 1 | Loss-of-signal state |
| los_delta | output | 1 | One-cycle pulse on each change of `los_state` |
| los_irq | output | 1 | Delta event passed through the mask |

## Verification
The bench tests the run threshold exactly at N and at N-1, including the largest threshold. A counter that is off by one would raise the state one byte early or fail to raise it at all.

Runs are also broken by non-uniform bytes and by a polarity flip, and stretched across idle cycles. A design that ignored the previous polarity, or that reset on idle cycles, would declare a loss too early or never declare one.

Recovery is interrupted in three ways: by a bad frame, by the external pin, and by a renewed run. A good-frame counter that was not cleared on these events would release the state one frame too soon.

Threshold zero is tested, along with masked transitions, which catch a divide-by-zero style stall and a leaking interrupt.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic [0:0] {
    LOS_CLEAR  = 1'b0,
    LOS_ACTIVE = 1'b1
  } los_st_e;

  typedef struct packed {
    logic is_zero;
    logic is_ones;
  } byte_class_t;

endpackage

// File: rtl/los_run_detect.sv
module los_run_detect #(
  parameter int DATA_W = 8,
  parameter int THR_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [THR_W-1:0]  run_thresh,
  output logic              run_hit
);
  import los_pkg::*;

  localparam logic [THR_W-1:0] THR_ONE = {{(THR_W-1){1'b0}}, 1'b1};
  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

  byte_class_t      cls;
  logic             uniform;
  logic             same_pol;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             pol_q, pol_d;
  logic [THR_W-1:0] thr_eff;

  // classify the incoming byte
  always_comb begin
    cls.is_zero = ~|rx_byte;
    cls.is_ones = &rx_byte;
    uniform     = cls.is_zero | cls.is_ones;
    same_pol    = (cnt_q != '0) && (cls.is_ones == pol_q);
  end

  // next-state of the run length counter
  always_comb begin
    cnt_d = cnt_q;
    pol_d = pol_q;
    if (byte_vld) begin
      if (uniform) begin
        pol_d = cls.is_ones;
        if (same_pol) begin
          if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + THR_ONE;
          end
        end else begin
          cnt_d = THR_ONE;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else if (byte_vld) begin
      cnt_q <= cnt_d;
      pol_q <= pol_d;
    end
  end

  always_comb begin
    thr_eff = (run_thresh == '0) ? THR_ONE : run_thresh;
    run_hit = (cnt_q >= thr_eff);
  end

endmodule

// File: rtl/los_recovery.sv
module los_recovery #(
  parameter int RECOVER_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_los,
  input  logic run_hit,
  input  logic frame_ok,
  input  logic frame_bad,
  output logic los_cur,
  output logic los_nxt
);
  import los_pkg::*;

  localparam int GW = (RECOVER_FRAMES < 2) ? 1 : $clog2(RECOVER_FRAMES + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(RECOVER_FRAMES - 1);
  localparam logic [GW-1:0] GOOD_ONE  = GW'(1);

  los_st_e       st_q, st_d;
  logic [GW-1:0] good_q, good_d;
  logic          cause;

  always_comb begin
    cause  = ext_los | run_hit;
    st_d   = st_q;
    good_d = good_q;
    if (cause) begin
      st_d   = LOS_ACTIVE;
      good_d = '0;
    end else if (st_q == LOS_ACTIVE) begin
      if (frame_bad) begin
        good_d = '0;
      end else if (frame_ok) begin
        if (good_q == GOOD_LAST) begin
          st_d   = LOS_CLEAR;
          good_d = '0;
        end else begin
          good_d = good_q + GOOD_ONE;
        end
      end
    end else begin
      good_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LOS_CLEAR;
      good_q <= '0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
    end
  end

  assign los_cur = (st_q == LOS_ACTIVE);
  assign los_nxt = (st_d == LOS_ACTIVE);

endmodule

// File: rtl/los_event.sv
module los_event (
  input  logic clk,
  input  logic rst_n,
  input  logic los_cur,
  input  logic los_nxt,
  input  logic irq_mask,
  output logic los_delta,
  output logic los_irq
);

  logic chg;
  logic delta_q, irq_q;

  always_comb begin
    chg = los_cur ^ los_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      delta_q <= chg;
      irq_q   <= chg & ~irq_mask;
    end
  end

  assign los_delta = delta_q;
  assign los_irq   = irq_q;

endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int DATA_W         = 8,
  parameter int THR_W          = 11,
  parameter int RECOVER_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [THR_W-1:0]  run_thresh,
  input  logic              ext_los,
  input  logic              frame_ok,
  input  logic              frame_bad,
  input  logic              irq_mask,
  output logic              los_state,
  output logic              los_delta,
  output logic              los_irq
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       run_hit;
  logic       los_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  los_run_detect #(
    .DATA_W (DATA_W),
    .THR_W  (THR_W)
  ) u_run (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .byte_vld   (byte_vld),
    .rx_byte    (rx_byte),
    .run_thresh (run_thresh),
    .run_hit    (run_hit)
  );

  los_recovery #(
    .RECOVER_FRAMES (RECOVER_FRAMES)
  ) u_rec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ext_los   (ext_los),
    .run_hit   (run_hit),
    .frame_ok  (frame_ok),
    .frame_bad (frame_bad),
    .los_cur   (los_state),
    .los_nxt   (los_nxt)
  );

  los_event u_evt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .los_cur   (los_state),
    .los_nxt   (los_nxt),
    .irq_mask  (irq_mask),
    .los_delta (los_delta),
    .los_irq   (los_irq)
  );

endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_los,
  input logic frame_ok,
  input logic irq_mask,
  input logic los_state,
  input logic los_delta,
  input logic los_irq
);

  assert_ext_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_los |=> los_state);

  assert_clear_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_state) |-> $past(frame_ok));

  assert_no_clear_with_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_state) |-> !$past(ext_los));

  assert_delta_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (los_state != $past(los_state)) |-> los_delta);

  assert_delta_only_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    los_delta |-> (los_state != $past(los_state)));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    los_irq |-> (los_delta && !$past(irq_mask)));

  assert_irq_unmasked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (los_delta && !$past(irq_mask)) |-> los_irq);

endmodule

bind los_monitor los_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .ext_los   (ext_los),
  .frame_ok  (frame_ok),
  .irq_mask  (irq_mask),
  .los_state (los_state),
  .los_delta (los_delta),
  .los_irq   (los_irq)
);

// File: tb/sim_los_monitor.sv
module sim_los_monitor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  rx_byte;
  logic [10:0] run_thresh;
  logic        ext_los;
  logic        frame_ok;
  logic        frame_bad;
  logic        irq_mask;
  logic        los_state, los_delta, los_irq;

  always #10 clk = ~clk;

  los_monitor u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .rx_byte    (rx_byte),
    .run_thresh (run_thresh),
    .ext_los    (ext_los),
    .frame_ok   (frame_ok),
    .frame_bad  (frame_bad),
    .irq_mask   (irq_mask),
    .los_state  (los_state),
    .los_delta  (los_delta),
    .los_irq    (los_irq)
  );

  typedef struct {
    logic  los;
    logic  delta;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic tb_mask = 1'b0;

  // requirement-level reference state
  int   m_len  = 0;
  logic m_ones = 1'b0;
  logic m_los  = 1'b0;
  int   m_good = 0;

  task automatic drive(input logic vld, input logic [7:0] b, input logic ext,
                       input logic fok, input logic fbad, input string tag);
    exp_t e;
    int   thr_eff;
    logic hit;
    logic nlos;
    byte_vld  = vld;
    rx_byte   = b;
    ext_los   = ext;
    frame_ok  = fok;
    frame_bad = fbad;
    irq_mask  = tb_mask;
    thr_eff = (run_thresh == 11'd0) ? 1 : int'(run_thresh);
    hit  = (m_len >= thr_eff);
    nlos = m_los;
    if (ext || hit) begin
      nlos = 1'b1;
      m_good = 0;
    end else if (m_los) begin
      if (fbad) m_good = 0;
      else if (fok) begin
        m_good = m_good + 1;
        if (m_good >= 2) begin
          nlos = 1'b0;
          m_good = 0;
        end
      end
    end
    e.los   = nlos;
    e.delta = (nlos != m_los);
    e.irq   = e.delta && !tb_mask;
    e.tag   = tag;
    m_los   = nlos;
    if (vld) begin
      if (b == 8'h00 || b == 8'hFF) begin
        if (m_len > 0 && ((b == 8'hFF) == m_ones)) m_len = m_len + 1;
        else m_len = 1;
        m_ones = (b == 8'hFF);
      end else begin
        m_len = 0;
      end
    end
    q.push_back(e);
    @(posedge clk);
    #8;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h3C, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic run_bytes(input logic [7:0] b, input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, b, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic good_frame(input string tag);
    drive(1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, tag);
    idle(3, tag);
  endtask

  task automatic recover(input string tag);
    drive(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, tag);
    good_frame(tag);
    good_frame(tag);
  endtask

  // monitor: pops one expectation per edge, after the edge settles
  always @(posedge clk) begin
    exp_t e;
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (los_state !== e.los || los_delta !== e.delta || los_irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s: state/delta/irq actual %b%b%b expected %b%b%b at %0t",
                 e.tag, los_state, los_delta, los_irq, e.los, e.delta, e.irq, $time);
      end
    end
  end

  task automatic chk_reset(input string tag);
    n_cmp++;
    if (los_state !== 1'b0 || los_delta !== 1'b0 || los_irq !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: outputs actual %b%b%b expected 000",
               tag, los_state, los_delta, los_irq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    byte_vld = 1'b0; rx_byte = 8'h3C; run_thresh = 11'd5;
    ext_los = 1'b0; frame_ok = 1'b0; frame_bad = 1'b0; irq_mask = 1'b0;
    repeat (3) @(posedge clk);
    #5 chk_reset("R1 in reset");
    ext_los = 1'b1;
    #2 rst_n = 1'b1;
    @(posedge clk); #5 chk_reset("R1 after release");
    ext_los = 1'b0;
    repeat (3) @(posedge clk);
    #8;

    // R2 + R10 + R7: external cause, recover with two frames
    drive(1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, "R2 pin");
    drive(1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, "R2 hold");
    idle(4, "R2 stays");
    good_frame("R10 pin cause frame1");
    good_frame("R7 pin cause frame2");

    // R3 threshold 5, N-1 then N
    run_thresh = 11'd5;
    run_bytes(8'h00, 4, "R3 short run");
    drive(1'b1, 8'h81, 1'b0, 1'b0, 1'b0, "R3 N-1 no los");
    idle(2, "R3 N-1 no los");
    run_bytes(8'h00, 5, "R3 run N");
    idle(3, "R3 raised");
    recover("R10 run cause");

    // R3 with 0xFF, threshold 3
    run_thresh = 11'd3;
    run_bytes(8'hFF, 3, "R3 ones run");
    idle(2, "R3 ones raised");
    recover("R7 after ones");

    // R4 polarity flip and non-uniform byte
    run_thresh = 11'd4;
    run_bytes(8'h00, 3, "R4 zeros");
    run_bytes(8'hFF, 3, "R4 flip");
    run_bytes(8'h00, 3, "R4 flip back");
    drive(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, "R4 break");
    run_bytes(8'h00, 3, "R4 restart");
    idle(2, "R4 no los");
    drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R4 fourth");
    idle(2, "R4 raised");
    recover("R4 recover");

    // R5 gaps do not break or extend
    run_bytes(8'hFF, 2, "R5 part1");
    idle(5, "R5 gap");
    run_bytes(8'hFF, 1, "R5 part2");
    idle(2, "R5 still 3");
    run_bytes(8'hFF, 1, "R5 part3");
    idle(2, "R5 raised");
    recover("R5 recover");

    // R6 threshold zero
    run_thresh = 11'd0;
    run_bytes(8'h00, 1, "R6 single");
    idle(2, "R6 raised");
    recover("R6 recover");

    // R8 bad frame restarts recovery
    run_thresh = 11'd2;
    drive(1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, "R8 set");
    good_frame("R8 f1");
    drive(1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, "R8 bad");
    good_frame("R8 f2 still los");
    good_frame("R8 f3 clears");

    // R9 pin and run during recovery; frame coincident with cause
    drive(1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, "R9 set");
    good_frame("R9 f1");
    drive(1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, "R9 pin with frame");
    good_frame("R9 f2 still los");
    run_bytes(8'h00, 2, "R9 run");
    drive(1'b1, 8'h11, 1'b0, 1'b1, 1'b0, "R9 frame with run");
    good_frame("R9 f3 still los");
    good_frame("R9 f4 clears");

    // R11/R12 masked transitions
    tb_mask = 1'b1;
    drive(1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, "R12 masked set");
    idle(2, "R12 masked");
    good_frame("R12 f1");
    good_frame("R12 masked clear");
    tb_mask = 1'b0;
    drive(1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, "R11 set");
    recover("R11 clear");

    // R3 boundary at the largest threshold
    run_thresh = 11'd2047;
    run_bytes(8'h00, 2046, "R3 max N-1");
    idle(2, "R3 max not yet");
    run_bytes(8'h00, 1, "R3 max N");
    idle(2, "R3 max raised");
    recover("R3 max recover");

    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule